// File: doc/BRIEF.md
# Ethernet Receive Frame Filter

This block sits between a byte-wide receive path and a 32-bit receive FIFO. A lower layer delivers one octet per valid cycle, with a start marker on the first octet of a frame and an end marker on the last. The filter checks each frame's destination address against a programmed 48-bit station address. It runs the IEEE 802.3 CRC-32 over the whole frame, FCS included. It then decides whether the frame stays in the FIFO.

Octets are packed four to a word and written at once, before the frame's fate is known. The filter keeps its own working write pointer. It publishes a separate committed pointer that a FIFO reader uses as the tail. When a frame is rejected at its end, the working pointer goes back to the frame's first word, so the next frame overwrites it. A rejected frame never becomes visible. A bad CRC can be set to cause rejection, and in that case it pulses an error interrupt. A FIFO clear request resets both pointers, but only while reception is disabled.

Top module: `eth_rx_filter`

## Requirements
- R1: With `crc_reject_en` high, a frame whose CRC check fails is dropped: `fifo_wptr` keeps its value from before the frame.
- R2: `rx_err_irq` pulses high for one cycle for each frame that ends with `rx_en` and `crc_reject_en` high and a failed CRC check, whatever its address. The pulse comes one cycle after the final octet's clock edge. It is never raised otherwise.
- R3: With `crc_reject_en` low, a frame with a matching address is kept whatever its CRC result, and no interrupt is raised.
- R4: A frame is kept only if its first six octets equal the station address. Received octet 0 is compared with `station_addr[47:40]`, octet 1 with `station_addr[39:32]`, and so on down to `station_addr[7:0]`. On a mismatch the frame is dropped, and a good CRC raises no interrupt.
- R5: A `fifo_clr_req` cycle with `rx_en` low sets `fifo_wptr` to 0 on the next edge. The next kept frame starts at word address 0.
- R6: A `fifo_clr_req` made while `rx_en` is high has no effect on `fifo_wptr`. The next kept frame continues at the existing pointer.
- R7: A kept frame occupies ceil(N/4) consecutive words for N octets, starting at the committed pointer and wrapping modulo `FIFO_DEPTH`. Octet 4k+j lands in bits 8j+7:8j of word k. Unused upper lanes of the final word are zero. The four FCS octets are stored as the frame's last octets.
- R8: After reset `fifo_wptr` is 0 and `fifo_we` and `rx_err_irq` are low. For a kept frame, `fifo_wptr` advances by ceil(N/4) two edges after the final octet's edge.
- R9: A frame whose start octet arrives with `rx_en` low is ignored entirely: no pointer change, no interrupt. A frame still in progress when `rx_en` is low at its end is dropped without interrupt.
- R10: The CRC passes when the CRC-32 residue over all octets, data plus FCS, equals 0xC704DD7B. Equivalently, the FCS is the complement of the reflected CRC-32 (initial value all ones) of the preceding octets, sent least significant byte first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receive enable |
| crc_reject_en | input | 1 | Drop frames with a failed CRC check and flag them |
| fifo_clr_req | input | 1 | FIFO clear request, honoured only with `rx_en` low |
| station_addr | input | 48 | Individual address, first-received octet in bits 47:40 |
| rx_valid | input | 1 | `rx_data` holds an octet this cycle |
| rx_sof | input | 1 | Octet is the first of a frame |
| rx_eof | input | 1 | Octet is the last of a frame |
| rx_data | input | 8 | Received octet |
| fifo_we | output | 1 | FIFO word write strobe |
| fifo_waddr | output | AW | FIFO word write address |
| fifo_wdata | output | 32 | FIFO word write data |
| fifo_wptr | output | AW | Committed tail pointer: words below it (modulo depth) hold kept frames |
| rx_err_irq | output | 1 | One-cycle receive error pulse |

## Verification
Several rules are checked on every cycle by assertions. An interrupt pulse must trace back to an end octet seen with rejection and reception enabled. A permitted clear must zero the committed pointer. A word write must follow an accepted octet. A rejected frame must leave the committed pointer alone. Other checks need the bench's scenarios. These include whether a given frame is kept or dropped, the exact packing and zero fill of the stored words, address byte order, the CRC criterion, and the ignored clear while enabled. The bench checks them against frames it builds and scores itself.

// File: rtl/eth_rx_filter_pkg.sv
package eth_rx_filter_pkg;

  localparam int unsigned MAC_OCTETS = 6;
  localparam int unsigned LANES      = 4;
  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
  localparam logic [31:0] CRC_RESIDUE   = 32'hC704DD7B;

  function automatic logic [31:0] bit_rev32(input logic [31:0] v);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = v[31-i];
    return r;
  endfunction

  // One octet of reflected CRC-32, LSB of the octet first.
  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++)
      r = (r >> 1) ^ (CRC_POLY_REFL & {32{r[0] ^ d[i]}});
    return r;
  endfunction

endpackage

// File: rtl/eth_rx_crc32.sv
module eth_rx_crc32
  import eth_rx_filter_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       octet_vld,
  input  logic       start,
  input  logic [7:0] octet,
  output logic       crc_ok
);
  // Residue as seen in a reflected shift register.
  localparam logic [31:0] RESID_REFL = bit_rev32(CRC_RESIDUE);

  logic [31:0] crc_q, crc_seed, crc_nx;

  assign crc_seed = start ? '1 : crc_q;
  assign crc_nx   = crc_step(crc_seed, octet);
  assign crc_ok   = (crc_nx == RESID_REFL);

  always_ff @(posedge clk) begin
    if (rst)            crc_q <= '1;
    else if (octet_vld) crc_q <= crc_nx;
  end

endmodule

// File: rtl/eth_rx_addr_match.sv
module eth_rx_addr_match
  import eth_rx_filter_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        octet_vld,
  input  logic        start,
  input  logic [7:0]  octet,
  input  logic [47:0] station_addr,
  output logic        addr_ok
);
  localparam int IDX_W = $clog2(MAC_OCTETS + 1);
  localparam int TAB_N = 2 ** IDX_W;
  localparam logic [IDX_W-1:0] IDX_FULL = IDX_W'(MAC_OCTETS);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(MAC_OCTETS - 1);

  logic [7:0] oct_tab [TAB_N];

  // First received octet sits in the top byte of station_addr.
  for (genvar g = 0; g < TAB_N; g++) begin : g_tab
    if (g < MAC_OCTETS) begin : g_real
      assign oct_tab[g] = station_addr[8*(MAC_OCTETS-g)-1 -: 8];
    end else begin : g_pad
      assign oct_tab[g] = 8'h00;
    end
  end

  logic [IDX_W-1:0] idx_q, idx_cur;
  logic             match_q, match_cur, oct_hit, match_nx;

  always_comb begin
    idx_cur   = start ? '0 : idx_q;
    match_cur = start ? 1'b1 : match_q;
    oct_hit   = (idx_cur >= IDX_FULL) || (octet == oct_tab[idx_cur]);
    match_nx  = match_cur && oct_hit;
    addr_ok   = match_nx && (idx_cur >= IDX_LAST);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q   <= '0;
      match_q <= 1'b0;
    end else if (octet_vld) begin
      match_q <= match_nx;
      idx_q   <= (idx_cur == IDX_FULL) ? idx_cur : idx_cur + IDX_W'(1);
    end
  end

endmodule

// File: rtl/eth_rx_word_packer.sv
module eth_rx_word_packer
  import eth_rx_filter_pkg::*;
#(
  parameter int unsigned AW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          octet_vld,
  input  logic          start,
  input  logic          busy,
  input  logic          last,
  input  logic          keep,
  input  logic          abort,
  input  logic [7:0]    octet,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [31:0]   wdata,
  output logic [AW-1:0] commit_ptr
);
  localparam int LANE_W = $clog2(LANES);
  localparam logic [LANE_W-1:0] LANE_TOP = LANE_W'(LANES - 1);

  logic [AW-1:0]     spec_q, frame_base_q, base_c, ptr_cur, rb_ptr;
  logic [LANE_W-1:0] lane_q, lane_cur;
  logic [31:0]       acc_q, word_c;
  logic              flush, pend_q;

  always_comb begin
    base_c   = busy ? frame_base_q : spec_q;   // restart rolls back
    ptr_cur  = start ? base_c : spec_q;
    lane_cur = start ? '0 : lane_q;
    word_c   = start ? '0 : acc_q;
    word_c[{lane_cur, 3'b000} +: 8] = octet;
    flush    = last || (lane_cur == LANE_TOP);
    rb_ptr   = start ? base_c : frame_base_q;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      spec_q       <= '0;
      frame_base_q <= '0;
      lane_q       <= '0;
      acc_q        <= '0;
      pend_q       <= 1'b0;
      commit_ptr   <= '0;
      we           <= 1'b0;
      waddr        <= '0;
      wdata        <= '0;
    end else begin
      we     <= 1'b0;
      pend_q <= 1'b0;
      if (pend_q) commit_ptr <= spec_q;
      if (abort) begin
        spec_q <= frame_base_q;
        lane_q <= '0;
        acc_q  <= '0;
      end else if (octet_vld) begin
        if (start) frame_base_q <= base_c;
        if (flush) begin
          we     <= 1'b1;
          waddr  <= ptr_cur;
          wdata  <= word_c;
          acc_q  <= '0;
          lane_q <= '0;
          spec_q <= ptr_cur + AW'(1);
        end else begin
          acc_q  <= word_c;
          lane_q <= lane_cur + LANE_W'(1);
          spec_q <= ptr_cur;
        end
        if (last) begin
          if (keep) pend_q <= 1'b1;
          else      spec_q <= rb_ptr;
        end
      end
    end
  end

  AST_REJECT_HOLDS_PTR: assert property (@(posedge clk) disable iff (rst || clr)
    (octet_vld && last && !keep && !pend_q) |=> ##1 $stable(commit_ptr)); // R1

endmodule

// File: rtl/eth_rx_filter.sv
module eth_rx_filter
  import eth_rx_filter_pkg::*;
#(
  parameter  int unsigned FIFO_DEPTH = 64,
  localparam int unsigned AW         = $clog2(FIFO_DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_en,
  input  logic          crc_reject_en,
  input  logic          fifo_clr_req,
  input  logic [47:0]   station_addr,
  input  logic          rx_valid,
  input  logic          rx_sof,
  input  logic          rx_eof,
  input  logic [7:0]    rx_data,
  output logic          fifo_we,
  output logic [AW-1:0] fifo_waddr,
  output logic [31:0]   fifo_wdata,
  output logic [AW-1:0] fifo_wptr,
  output logic          rx_err_irq
);
  logic in_frame_q, clr, start, abort, octet_vld, last, keep;
  logic crc_ok, addr_ok;

  assign clr       = fifo_clr_req && !rx_en;
  assign start     = rx_valid && rx_sof && rx_en;
  assign abort     = rx_valid && rx_sof && !rx_en && in_frame_q;
  assign octet_vld = start || (rx_valid && !rx_sof && in_frame_q);
  assign last      = octet_vld && rx_eof;
  assign keep      = rx_en && addr_ok && (crc_ok || !crc_reject_en);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      in_frame_q <= 1'b0;
      rx_err_irq <= 1'b0;
    end else begin
      rx_err_irq <= last && rx_en && crc_reject_en && !crc_ok;
      if (abort)          in_frame_q <= 1'b0;
      else if (octet_vld) in_frame_q <= !rx_eof;
    end
  end

  eth_rx_crc32 i_crc (
    .clk(clk), .rst(rst), .octet_vld(octet_vld), .start(start),
    .octet(rx_data), .crc_ok(crc_ok)
  );

  eth_rx_addr_match i_addr (
    .clk(clk), .rst(rst), .octet_vld(octet_vld), .start(start),
    .octet(rx_data), .station_addr(station_addr), .addr_ok(addr_ok)
  );

  eth_rx_word_packer #(.AW(AW)) i_pack (
    .clk(clk), .rst(rst), .clr(clr), .octet_vld(octet_vld), .start(start),
    .busy(in_frame_q), .last(last), .keep(keep), .abort(abort), .octet(rx_data),
    .we(fifo_we), .waddr(fifo_waddr), .wdata(fifo_wdata), .commit_ptr(fifo_wptr)
  );

  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
    rx_err_irq |-> $past(rx_valid && rx_eof && rx_en && crc_reject_en)); // R2

  AST_CLR_ZEROES: assert property (@(posedge clk) disable iff (rst)
    (fifo_clr_req && !rx_en) |=> (fifo_wptr == '0 && !fifo_we)); // R5

  AST_WE_FROM_OCTET: assert property (@(posedge clk) disable iff (rst)
    fifo_we |-> $past(rx_valid)); // R7

endmodule

// File: tb/test_eth_rx_filter.sv
module test_eth_rx_filter;
  localparam int DEPTH = 64;
  localparam int AW    = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rst, rx_en, crc_reject_en, fifo_clr_req;
  logic [47:0]   station_addr;
  logic          rx_valid, rx_sof, rx_eof;
  logic [7:0]    rx_data;
  logic          fifo_we, rx_err_irq;
  logic [AW-1:0] fifo_waddr, fifo_wptr;
  logic [31:0]   fifo_wdata;

  always #2 clk = ~clk;

  eth_rx_filter #(.FIFO_DEPTH(DEPTH)) i_eth_rx_filter (
    .clk(clk), .rst(rst), .rx_en(rx_en), .crc_reject_en(crc_reject_en),
    .fifo_clr_req(fifo_clr_req), .station_addr(station_addr),
    .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_data(rx_data),
    .fifo_we(fifo_we), .fifo_waddr(fifo_waddr), .fifo_wdata(fifo_wdata),
    .fifo_wptr(fifo_wptr), .rx_err_irq(rx_err_irq)
  );

  logic [31:0] shadow [DEPTH];
  int irq_cnt = 0;
  int n_chk = 0, n_err = 0;
  int exp_ptr = 0;
  logic [7:0] frm [256];
  int flen;

  always @(posedge clk) begin
    if (fifo_we) shadow[fifo_waddr] <= fifo_wdata;
    if (rx_err_irq) irq_cnt <= irq_cnt + 1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] model_crc(input int n);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int i = 0; i < n; i++)
      for (int b = 0; b < 8; b++)
        c = (c >> 1) ^ ((c[0] ^ frm[i][b]) ? 32'hEDB88320 : 32'h0);
    return c;
  endfunction

  task automatic build(input logic [47:0] dst, input int plen, input bit bad);
    logic [31:0] fcs;
    for (int i = 0; i < 6; i++) frm[i] = dst[47-8*i -: 8];
    for (int i = 0; i < plen; i++) frm[6+i] = 8'($urandom);
    fcs = ~model_crc(6 + plen);
    for (int k = 0; k < 4; k++) frm[6+plen+k] = fcs[8*k +: 8];
    flen = 10 + plen;
    if (bad) frm[flen-1] = frm[flen-1] ^ 8'h10;
  endtask

  task automatic send();
    for (int i = 0; i < flen; i++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_sof = (i == 0); rx_eof = (i == flen - 1); rx_data = frm[i];
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic run_frame(input logic [47:0] dst, input int plen, input bit bad,
                           input bit en, input bit rej, input string req);
    bit keep, irq;
    int irq0, nw;
    logic [31:0] w;
    build(dst, plen, bad);
    keep = en && (dst == station_addr) && (!bad || !rej);
    irq  = en && rej && bad;
    @(negedge clk);
    rx_en = en; crc_reject_en = rej;
    irq0 = irq_cnt;
    send();
    chk((irq_cnt - irq0) == int'(irq), {req, "/R2"}, "irq pulses", irq_cnt - irq0, irq);
    if (keep) begin
      nw = (flen + 3) / 4;
      for (int k = 0; k < nw; k++) begin
        w = '0;
        for (int j = 0; j < 4; j++)
          if (4*k + j < flen) w[8*j +: 8] = frm[4*k + j];
        chk(shadow[(exp_ptr + k) % DEPTH] == w, "R7", "packed word",
            shadow[(exp_ptr + k) % DEPTH], w);
      end
      exp_ptr = (exp_ptr + nw) % DEPTH;
    end
    chk(int'(fifo_wptr) == exp_ptr, {req, "/R8"}, "committed ptr", fifo_wptr, exp_ptr);
  endtask

  task automatic clear_req(input bit en, input string req);
    @(negedge clk);
    rx_en = en; fifo_clr_req = 1'b1;
    @(negedge clk);
    fifo_clr_req = 1'b0;
    repeat (2) @(negedge clk);
    if (!en) exp_ptr = 0;
    chk(int'(fifo_wptr) == exp_ptr, req, "ptr after clear", fifo_wptr, exp_ptr);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [47:0] other;
    void'($urandom(32'd2024));
    rst = 1'b1; rx_en = 1'b0; crc_reject_en = 1'b1; fifo_clr_req = 1'b0;
    rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_data = '0;
    station_addr = 48'h02_1A_3B_4C_5D_6E;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(fifo_wptr == '0 && !fifo_we && !rx_err_irq, "R8", "reset state",
        {fifo_we, rx_err_irq, fifo_wptr}, 0);

    run_frame(station_addr, 10, 0, 1, 1, "R10");            // kept, residue passes
    run_frame(station_addr, 11, 0, 1, 1, "R7");             // partial last word
    run_frame(station_addr ^ 48'h1, 12, 0, 1, 1, "R4");     // last address octet differs
    run_frame(48'h6E_5D_4C_3B_1A_02, 8, 0, 1, 1, "R4");     // reversed octet order
    run_frame(station_addr, 9, 1, 1, 1, "R1");              // bad CRC dropped
    run_frame(station_addr ^ 48'h0100, 9, 1, 1, 1, "R2");   // bad CRC, other address
    run_frame(station_addr, 13, 1, 1, 0, "R3");             // bad CRC kept
    run_frame(station_addr, 7, 1, 0, 1, "R9");              // receiver disabled
    clear_req(1'b1, "R6");
    run_frame(station_addr, 5, 0, 1, 1, "R6");
    clear_req(1'b0, "R5");
    run_frame(station_addr, 0, 0, 1, 1, "R5");

    for (int n = 0; n < 40; n++) begin
      other = station_addr ^ (48'h1 << (8 * ($urandom % 6)));
      run_frame(($urandom % 3 != 0) ? station_addr : other, $urandom % 41,
                ($urandom % 3 == 0), ($urandom % 8 != 0), $urandom % 2, "R1/R3/R4");
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule